// File: doc/BRIEF.md
# Protected Page Write Controller

This block owns a small array of user pages held in flip-flops, plus a short administrative area that stores a two-bit protection code for each page. A command stream carries reads and writes addressed by page and byte offset; each write is merged into the stored byte according to the addressed page's code. A page can take any new value, refuse every change, or accept only the AND of its old and new contents. In the last case bits can only fall from 1 to 0, so a page starting in the erased state can be used as a counter that only counts down.

Commands arrive on a valid/ready channel. Each accepted command produces exactly one response on a second valid/ready channel, in order. A command is accepted only when the one-entry response slot is empty or is being drained in the same cycle. This means back-pressure on the response side stalls the command side directly, with no hidden buffering. A sticky error flag reports the last write outcome, and the full user array is visible on a flat output bus.

Top module: `prot_page_writer`

## Requirements
- R1: After reset every user byte reads 0xFF, every administrative byte is 0x00 (so every page is in unrestricted mode), `err_flag` is 0, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: The code of page p sits in administrative bits [2p+1:2p], counting byte 0 as bits 7:0 and byte 1 as bits 15:8. The codes are 00 unrestricted, 01 protected, 10 AND-merge and 11 reserved.
- R3: A write to an in-range byte of a page with code 00 stores the write byte. The response carries that byte with `rsp_reject` = 0.
- R4: A write to a page with code 01 or 11 leaves the array unchanged. The response carries the unchanged stored byte with `rsp_reject` = 1.
- R5: A write to a page with code 10 stores old AND new, with `rsp_reject` = 0. A 0 bit is never restored to 1.
- R6: A write to page 7, or to an administrative offset of 8 or more, changes nothing. The response carries data 0x00 with `rsp_reject` = 1.
- R7: `err_flag` takes the reject value of each accepted write one cycle after acceptance, so it sets on a rejected write and clears on the next accepted write. Reads never change it.
- R8: Writes to the administrative area (`cmd_admin` = 1) at offsets 0 to 7 always overwrite the byte. A changed code governs commands accepted after that write.
- R9: A read returns the stored byte with `rsp_reject` = 0. A read of page 7, or of an administrative offset of 8 or more, returns 0x00 with `rsp_reject` = 1.
- R10: `cmd_ready` equals `!rsp_valid || rsp_ready`. Each accepted command yields one response in the next cycle, in order. While `rsp_valid` is high and `rsp_ready` is low, the response holds stable.
- R11: `mem_image` bits [(16p+b)*8 +: 8] show byte b of user page p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_admin | input | 1 | 1 selects the administrative area |
| cmd_page | input | 3 | User page index |
| cmd_offset | input | 4 | Byte offset within page or area |
| cmd_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Stored byte after the command |
| rsp_reject | output | 1 | Command was refused or out of range |
| err_flag | output | 1 | Sticky outcome of the last write |
| mem_image | output | 896 | Flat view of all user pages |

## Verification
The properties assume that `rst_n` is held low for at least one clock edge before any command, and that command fields stay meaningful whenever `cmd_valid` is high. They also assume the consumer eventually raises `rsp_ready`. The stimulus drives and changes commands only between clock edges, holds every field steady until the handshake completes, and alternates full-rate draining with phases where `rsp_ready` is low in three of every four cycles. The out-of-range properties read `cmd_page` and `cmd_offset` only during accepted cycles, so driving page 7 or offsets beyond the administrative area stays within what the checker allows.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

  typedef enum logic [1:0] {
    MODE_OPEN = 2'b00,
    MODE_LOCK = 2'b01,
    MODE_AND  = 2'b10,
    MODE_RSVD = 2'b11
  } page_mode_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam logic [7:0] ADMIN_INIT  = 8'h00;

endpackage

// File: rtl/ppw_mode_decode.sv
module ppw_mode_decode
  import ppw_pkg::*;
#(
  parameter int PAGES = 7
) (
  input  logic [2*PAGES-1:0] mode_bits,
  output logic [PAGES-1:0]   lock_vec,
  output logic [PAGES-1:0]   and_vec
);

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    page_mode_e code;
    assign code = page_mode_e'(mode_bits[2*p +: 2]);
    always_comb begin
      lock_vec[p] = 1'b0;
      and_vec[p]  = 1'b0;
      unique case (code)
        MODE_OPEN: ;
        MODE_LOCK: lock_vec[p] = 1'b1;
        MODE_AND:  and_vec[p]  = 1'b1;
        MODE_RSVD: lock_vec[p] = 1'b1;
        default:   lock_vec[p] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ppw_merge.sv
module ppw_merge (
  input  logic       is_write,
  input  logic       is_admin,
  input  logic       in_range,
  input  logic       lock,
  input  logic       and_mode,
  input  logic [7:0] old_byte,
  input  logic [7:0] new_byte,
  output logic [7:0] result,
  output logic       commit,
  output logic       reject
);

  always_comb begin
    result = old_byte;
    commit = 1'b0;
    reject = 1'b0;
    if (!in_range) begin
      result = 8'h00;
      reject = 1'b1;
    end else if (is_write) begin
      if (is_admin) begin
        result = new_byte;
        commit = 1'b1;
      end else if (lock) begin
        reject = 1'b1;
      end else if (and_mode) begin
        result = old_byte & new_byte;
        commit = 1'b1;
      end else begin
        result = new_byte;
        commit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ppw_store.sv
module ppw_store
  import ppw_pkg::*;
#(
  parameter int PAGES       = 7,
  parameter int PAGE_BYTES  = 16,
  parameter int ADMIN_BYTES = 8,
  parameter int PG_W        = 3,
  parameter int OFS_W       = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          sel_admin,
  input  logic [PG_W-1:0]               sel_page,
  input  logic [OFS_W-1:0]              sel_ofs,
  input  logic [7:0]                    wr_data,
  output logic [7:0]                    rd_data,
  output logic [PAGES*PAGE_BYTES*8-1:0] user_flat,
  output logic [2*PAGES-1:0]            mode_bits
);

  localparam int ADMIN_W = ADMIN_BYTES * 8;

  logic [7:0] user_q  [PAGES][PAGE_BYTES];
  logic [7:0] admin_q [ADMIN_BYTES];
  logic [ADMIN_W-1:0] admin_flat;

  for (genvar p = 0; p < PAGES; p++) begin : g_pg
    for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_by
      logic hit;
      assign hit = wr_en && !sel_admin && (sel_page == PG_W'(p)) && (sel_ofs == OFS_W'(b));
      always_ff @(posedge clk) begin
        if (!rst_n)   user_q[p][b] <= ERASED_BYTE;
        else if (hit) user_q[p][b] <= wr_data;
      end
      assign user_flat[(p*PAGE_BYTES+b)*8 +: 8] = user_q[p][b];
    end
  end

  for (genvar a = 0; a < ADMIN_BYTES; a++) begin : g_adm
    logic hit;
    assign hit = wr_en && sel_admin && (sel_ofs == OFS_W'(a));
    always_ff @(posedge clk) begin
      if (!rst_n)   admin_q[a] <= ADMIN_INIT;
      else if (hit) admin_q[a] <= wr_data;
    end
    assign admin_flat[a*8 +: 8] = admin_q[a];
  end

  assign mode_bits = admin_flat[2*PAGES-1:0];

  always_comb begin
    rd_data = 8'h00;
    if (sel_admin) begin
      for (int a = 0; a < ADMIN_BYTES; a++)
        if (sel_ofs == OFS_W'(a)) rd_data = admin_q[a];
    end else begin
      for (int p = 0; p < PAGES; p++)
        for (int b = 0; b < PAGE_BYTES; b++)
          if (sel_page == PG_W'(p) && sel_ofs == OFS_W'(b)) rd_data = user_q[p][b];
    end
  end

endmodule

// File: rtl/ppw_rsp_slot.sv
module ppw_rsp_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       load_reject,
  input  logic       rsp_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_reject,
  output logic       can_load
);

  assign can_load = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= 8'h00;
      rsp_reject <= 1'b0;
    end else if (load) begin
      rsp_valid  <= 1'b1;
      rsp_data   <= load_data;
      rsp_reject <= load_reject;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/prot_page_writer.sv
module prot_page_writer
  import ppw_pkg::*;
#(
  parameter int PAGES       = 7,
  parameter int PAGE_BYTES  = 16,
  parameter int ADMIN_BYTES = 8,
  parameter int PG_W        = $clog2(PAGES + 1),
  parameter int OFS_W       = $clog2(PAGE_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic                          cmd_write,
  input  logic                          cmd_admin,
  input  logic [PG_W-1:0]               cmd_page,
  input  logic [OFS_W-1:0]              cmd_offset,
  input  logic [7:0]                    cmd_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [7:0]                    rsp_data,
  output logic                          rsp_reject,
  output logic                          err_flag,
  output logic [PAGES*PAGE_BYTES*8-1:0] mem_image
);

  localparam logic [PG_W:0]  PAGE_LIM  = (PG_W+1)'(PAGES);
  localparam logic [OFS_W:0] ADMIN_LIM = (OFS_W+1)'(ADMIN_BYTES);
  localparam logic [OFS_W:0] BYTE_LIM  = (OFS_W+1)'(PAGE_BYTES);

  logic               accept;
  logic               in_range;
  logic [7:0]         old_byte;
  logic [2*PAGES-1:0] mode_bits;
  logic [PAGES-1:0]   lock_vec, and_vec;
  logic               sel_lock, sel_and;
  logic [7:0]         merged;
  logic               commit, reject;
  logic               slot_free;

  assign in_range = cmd_admin ? ({1'b0, cmd_offset} < ADMIN_LIM)
                              : (({1'b0, cmd_page} < PAGE_LIM) && ({1'b0, cmd_offset} < BYTE_LIM));

  assign cmd_ready = slot_free;
  assign accept    = cmd_valid && cmd_ready;

  ppw_store #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .ADMIN_BYTES(ADMIN_BYTES),
    .PG_W(PG_W), .OFS_W(OFS_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && commit),
    .sel_admin(cmd_admin), .sel_page(cmd_page), .sel_ofs(cmd_offset),
    .wr_data(merged), .rd_data(old_byte),
    .user_flat(mem_image), .mode_bits(mode_bits)
  );

  ppw_mode_decode #(.PAGES(PAGES)) decode_i (
    .mode_bits(mode_bits), .lock_vec(lock_vec), .and_vec(and_vec)
  );

  always_comb begin
    sel_lock = 1'b0;
    sel_and  = 1'b0;
    for (int p = 0; p < PAGES; p++) begin
      if (cmd_page == PG_W'(p)) begin
        sel_lock = lock_vec[p];
        sel_and  = and_vec[p];
      end
    end
  end

  ppw_merge merge_i (
    .is_write(cmd_write), .is_admin(cmd_admin), .in_range(in_range),
    .lock(sel_lock), .and_mode(sel_and),
    .old_byte(old_byte), .new_byte(cmd_wdata),
    .result(merged), .commit(commit), .reject(reject)
  );

  ppw_rsp_slot slot_i (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_data(merged), .load_reject(reject),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_reject(rsp_reject), .can_load(slot_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    err_flag <= 1'b0;
    else if (accept && cmd_write)  err_flag <= reject;
  end

endmodule

// File: rtl/ppw_checker.sv
module ppw_checker #(
  parameter int PAGES       = 7,
  parameter int PAGE_BYTES  = 16,
  parameter int PG_W        = 3,
  parameter int OFS_W       = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cmd_valid,
  input logic                          cmd_ready,
  input logic                          cmd_write,
  input logic                          cmd_admin,
  input logic [PG_W-1:0]               cmd_page,
  input logic [OFS_W-1:0]              cmd_offset,
  input logic [7:0]                    cmd_wdata,
  input logic                          rsp_valid,
  input logic                          rsp_ready,
  input logic [7:0]                    rsp_data,
  input logic                          rsp_reject,
  input logic                          err_flag,
  input logic [PAGES*PAGE_BYTES*8-1:0] mem_image,
  input logic [2*PAGES-1:0]            mode_bits,
  input logic [7:0]                    old_byte
);

  localparam logic [PG_W:0] PAGE_LIM = (PG_W+1)'(PAGES);

  logic       acc, user_wr, pg_ok;
  logic [1:0] code;

  assign acc     = cmd_valid && cmd_ready;
  assign pg_ok   = {1'b0, cmd_page} < PAGE_LIM;
  assign user_wr = acc && cmd_write && !cmd_admin;

  always_comb begin
    code = 2'b00;
    for (int p = 0; p < PAGES; p++)
      if (cmd_page == PG_W'(p)) code = mode_bits[2*p +: 2];
  end

  // R10: response held under back-pressure
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_reject));

  // R10: empty slot always takes a command
  p_ready_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> cmd_ready);

  // R10: every accepted command produces a response
  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R6: out-of-range page write changes nothing
  p_oob_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    user_wr && !pg_ok |=> $stable(mem_image) && rsp_reject && rsp_data == 8'h00);

  // R4: protected or reserved page keeps its data
  p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    user_wr && pg_ok && code[0] |=> $stable(mem_image) && rsp_reject);

  // R5: AND-merge stores old AND new
  p_and_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    user_wr && pg_ok && code == 2'b10 |=>
      !rsp_reject && rsp_data == ($past(old_byte) & $past(cmd_wdata)));

  // R7: flag follows each write outcome
  p_err_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_write |=> err_flag == rsp_reject);

  // R7: reads leave the flag alone
  p_err_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmd_write |=> $stable(err_flag));

  // R3: open page stores the write byte
  p_open_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    user_wr && pg_ok && code == 2'b00 |=> !rsp_reject && rsp_data == $past(cmd_wdata));

  logic unused_ok;
  assign unused_ok = ^cmd_offset;

endmodule

bind prot_page_writer ppw_checker #(
  .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PG_W(PG_W), .OFS_W(OFS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_admin(cmd_admin), .cmd_page(cmd_page),
  .cmd_offset(cmd_offset), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_reject(rsp_reject),
  .err_flag(err_flag), .mem_image(mem_image), .mode_bits(mode_bits),
  .old_byte(old_byte)
);

// File: tb/prot_page_writer_tb_top.sv
module prot_page_writer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 7;
  localparam int NB = 16;
  localparam int NA = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_admin = 1'b0;
  logic [2:0] cmd_page = '0;
  logic [3:0] cmd_offset = '0;
  logic [7:0] cmd_wdata = '0;
  logic rsp_ready = 1'b1;
  logic cmd_ready, rsp_valid, rsp_reject, err_flag;
  logic [7:0] rsp_data;
  logic [NP*NB*8-1:0] mem_image;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_page_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_admin(cmd_admin), .cmd_page(cmd_page),
    .cmd_offset(cmd_offset), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_reject(rsp_reject),
    .err_flag(err_flag), .mem_image(mem_image)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] user_m [NP][NB];
  logic [7:0] admin_m [NA];
  logic err_m = 1'b0;
  logic [8:0] exp_q [$];
  string tag_q [$];
  logic stall = 1'b0;
  int cyc = 0;
  logic held = 1'b0;
  logic [8:0] held_val = '0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Monitor: decides rsp_ready, pops scoreboard on each handshake
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (held)
        check(rsp_valid && {rsp_reject, rsp_data} == held_val, "R10", "held response",
              {22'd0, rsp_valid, rsp_reject, rsp_data}, {23'd1, held_val});
      rsp_ready = stall ? (cyc % 4 == 0) : 1'b1;
      held = rsp_valid && !rsp_ready;
      held_val = {rsp_reject, rsp_data};
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected response", {23'd0, rsp_reject, rsp_data}, 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_reject, rsp_data} == e, t, "response {reject,data}",
                {23'd0, rsp_reject, rsp_data}, {23'd0, e});
        end
      end
    end
  end

  function automatic logic [1:0] mode_of(input int p);
    logic [7:0] byt;
    byt = admin_m[(2*p)/8];
    return 2'((byt >> ((2*p) % 8)) & 8'h3);
  endfunction

  // Driver: computes expected result from the requirements, pushes, then drives
  task automatic send(input bit wr, input bit adm, input int pg, input int ofs,
                      input logic [7:0] d, input string req);
    logic [7:0] ed;
    logic er;
    bit inr;
    @(negedge clk); #1;
    cmd_write = wr; cmd_admin = adm; cmd_page = 3'(pg);
    cmd_offset = 4'(ofs); cmd_wdata = d; cmd_valid = 1'b1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    inr = adm ? (ofs < NA) : (pg < NP && ofs < NB);
    ed = 8'h00; er = 1'b1;
    if (inr) begin
      er = 1'b0;
      if (adm) begin
        if (wr) admin_m[ofs] = d;
        ed = admin_m[ofs];
      end else if (!wr) begin
        ed = user_m[pg][ofs];
      end else begin
        case (mode_of(pg))
          2'b00: user_m[pg][ofs] = d;
          2'b10: user_m[pg][ofs] = user_m[pg][ofs] & d;
          default: er = 1'b1;
        endcase
        ed = user_m[pg][ofs];
      end
    end
    if (wr) err_m = er;
    exp_q.push_back({er, ed});
    tag_q.push_back(req);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    check(err_flag == err_m, "R7", "err_flag", {31'd0, err_flag}, {31'd0, err_m});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < NB; b++) user_m[p][b] = 8'hFF;
    for (int a = 0; a < NA; a++) admin_m[a] = 8'h00;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(mem_image == {NP*NB{8'hFF}}, "R1", "erased array", 0, 0);
    check(!err_flag && !rsp_valid && cmd_ready, "R1", "idle outputs",
          {29'd0, err_flag, rsp_valid, cmd_ready}, 1);

    send(0, 0, 0, 0, 8'h00, "R1");
    send(0, 1, 0, 0, 8'h00, "R1");
    send(1, 0, 2, 5, 8'h5A, "R3");
    send(0, 0, 2, 5, 8'h00, "R3");
    send(1, 1, 0, 0, 8'h84, "R8");
    send(1, 1, 1, 0, 8'h23, "R8");
    send(1, 0, 1, 0, 8'h00, "R4");
    send(0, 0, 0, 3, 8'h00, "R9");
    send(1, 0, 3, 2, 8'hF0, "R5");
    send(1, 0, 3, 2, 8'h3C, "R5");
    send(1, 0, 3, 2, 8'hFF, "R5");
    send(1, 0, 4, 9, 8'h00, "R4");
    send(1, 0, 6, 15, 8'h7F, "R2");
    send(1, 0, 5, 1, 8'h11, "R2");
    send(1, 0, 7, 0, 8'h00, "R6");
    send(1, 0, 0, 0, 8'h42, "R3");
    send(1, 1, 0, 9, 8'h55, "R6");
    send(0, 0, 7, 4, 8'h00, "R9");
    send(0, 1, 0, 12, 8'h00, "R9");
    send(1, 1, 0, 0, 8'h80, "R8");
    send(1, 0, 1, 0, 8'h00, "R8");
    drain();

    stall = 1'b1;
    for (int i = 0; i < 60; i++) begin
      int pg, ofs;
      logic [7:0] d;
      pg  = (i * 5 + 1) % 8;
      ofs = (i * 7 + 3) % 16;
      d   = 8'((i * 37) ^ 8'hA5);
      if (i % 9 == 4) send(1, 1, 0, i % 2, 8'((i * 13) & 8'hEE), "R8");
      else            send(i % 3 != 0, 0, pg, ofs, d, "R10");
    end
    stall = 1'b0;
    drain();

    for (int p = 0; p < NP; p++)
      for (int b = 0; b < NB; b++)
        check(mem_image[(p*NB+b)*8 +: 8] == user_m[p][b], "R11", "image byte",
              {24'd0, mem_image[(p*NB+b)*8 +: 8]}, {24'd0, user_m[p][b]});
    finish_run();
  end

endmodule